// File: doc/BRIEF.md
# Adaptive Multi-Pixel Multiplier Pool

This block computes 3x3 convolution results for several neighbouring output pixels at once, using a fixed pool of multipliers. The mask is described by a small set of distinct coefficient values, plus a group index for each of the nine taps. For each pixel, the window samples that share a coefficient are first added together. Each of those group sums then occupies one multiplier, and the products of a pixel are added into its result. A mask with few distinct coefficients therefore needs few multipliers per pixel, and the rest of the pool serves further pixels in the same pass.

Configuration is loaded while no pass is in flight. Loading latches the distinct-coefficient count, the coefficient values and the tap grouping. It also builds a routing table that assigns every multiplier to a pixel and to a group. The multipliers left over after the last whole pixel are held disabled.

A pass presents up to eighteen windows, each qualified by its own lane bit. The pass comes out on the result lanes after a fixed latency, with a mask marking the lanes that carry a result. A new pass may start on every clock.

Top module: `mpool_conv`

## Requirements
- R1: After reset `out_valid` and `out_lanes` are zero and the block is unconfigured. Any pass offered (`in_valid` high) before the first accepted configuration is dropped and produces no output.
- R2: `cfg_load` samples `cfg_uniq` (the distinct-coefficient count U). A value of 0 or a value above 9 is rejected, and the previous configuration, or the unconfigured state, is kept.
- R3: `cfg_load` is ignored in two cases: when `in_valid` is high in the same cycle, or when a pass was accepted at any of the three preceding clock edges. The configuration then in force is unchanged.
- R4: Pixels per pass is floor(18/U): U=1 gives 18, 2 gives 9, 3 gives 6, 4 gives 4, 5 and 6 give 3, and 7 to 9 give 2. Multiplier j serves pixel j/U and group j mod U. Multipliers at or above (pixels per pass)*U are disabled.
- R5: The result for lane p is the sum, over the nine taps t, of window sample t multiplied by coefficient `cfg_grp[t]`. Samples are unsigned 8-bit values. Lane p tap t sits at `in_win[(p*9+t)*8 +: 8]`, with tap t = row*3+col. Coefficient g is a signed 8-bit value at `cfg_coef[g*8 +: 8]`. The tap-t group index sits at `cfg_grp[t*4 +: 4]`. Results are signed 25-bit values at `out_pix[p*25 +: 25]`.
- R6: `out_lanes[p]` is 1 exactly when p is below the pixels-per-pass count and `in_lanes[p]` was 1. Lanes not marked read zero.
- R7: A pass accepted at a clock edge sets `out_valid` for one cycle after the third edge, counting the accepting edge as the first. Passes on consecutive cycles give results on consecutive cycles.
- R8: A tap whose group index is U or larger contributes nothing to any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Configuration load strobe |
| cfg_uniq | input | 4 | Distinct-coefficient count U |
| cfg_coef | input | 72 | Nine signed coefficients, group g at bits g*8 |
| cfg_grp | input | 36 | Group index per tap, tap t at bits t*4 |
| in_valid | input | 1 | Pass offered this cycle |
| in_lanes | input | 18 | Per-window valid qualifiers |
| in_win | input | 1296 | Eighteen 3x3 windows of 8-bit samples |
| out_valid | output | 1 | Result lanes valid this cycle |
| out_lanes | output | 18 | Lanes that carry a result |
| out_pix | output | 450 | Eighteen signed 25-bit results |

## Verification
A configuration load and a pass can arrive in the same cycle. A load can also arrive while earlier passes are still in the pipeline, and the routing table must not change under them. The bench provokes both. It raises `cfg_load` together with `in_valid`. It also raises `cfg_load` one to three cycles after a pass, and exactly one cycle after the busy window has closed. It judges the outcome by whether the passes that follow are computed with the old mask or the new one, and whether the lane count is the old count or the new one. A behavioural model predicts results on every clock, from the mask arithmetic alone and without the multiplier mapping.

// File: rtl/mp_pkg.sv
package mp_pkg;

  localparam int unsigned MP_NMUL = 18;
  localparam int unsigned MP_NTAP = 9;
  localparam int unsigned MP_LAT  = 3;

  typedef enum logic [1:0] {
    ST_UNCFG = 2'd0,
    ST_IDLE  = 2'd1,
    ST_BUSY  = 2'd2
  } mp_state_e;

  // pixels served per pass for a given distinct-coefficient count
  function automatic int mp_ppp(input int nmul, input int u);
    return (u < 1) ? 0 : nmul / u;
  endfunction

  function automatic logic mp_u_ok(input int ntap, input int u);
    return (u >= 1) && (u <= ntap);
  endfunction

endpackage

// File: rtl/mp_ctrl.sv
module mp_ctrl
  import mp_pkg::*;
#(
  parameter int NMUL = 18,
  parameter int NTAP = 9,
  parameter int CW   = 8,
  parameter int UW   = 4,
  parameter int PXW  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_load,
  input  logic [UW-1:0]        cfg_uniq,
  input  logic [NTAP*CW-1:0]   cfg_coef,
  input  logic [NTAP*UW-1:0]   cfg_grp,
  input  logic                 in_valid,
  input  logic                 pipe_busy,
  output logic                 pass_acc,
  output logic [UW-1:0]        cfg_u,
  output logic signed [CW-1:0] coef_q [NTAP],
  output logic [UW-1:0]        grp_q [NTAP],
  output logic [PXW-1:0]       pix_sel [NMUL],
  output logic [UW-1:0]        grp_sel [NMUL],
  output logic [NMUL-1:0]      mul_en,
  output logic [NMUL-1:0]      lane_cap
);

  localparam int CNTW = $clog2(MP_LAT + 1);

  mp_state_e       state;
  logic [CNTW-1:0] cnt;
  logic            cfg_acc;

  logic [PXW-1:0]  pix_n [NMUL];
  logic [UW-1:0]   grp_n [NMUL];
  logic [NMUL-1:0] en_n, cap_n;

  assign pass_acc = in_valid && (state != ST_UNCFG);
  assign cfg_acc  = cfg_load && !in_valid && (state != ST_BUSY) &&
                    mp_u_ok(NTAP, int'(cfg_uniq));

  // routing table built from the count being loaded
  always_comb begin
    int u, ppp;
    u   = int'(cfg_uniq);
    ppp = mp_ppp(NMUL, u);
    for (int j = 0; j < NMUL; j++) begin
      pix_n[j] = (u != 0) ? PXW'(j / u) : '0;
      grp_n[j] = (u != 0) ? UW'(j % u)  : '0;
      en_n[j]  = (j < ppp * u);
      cap_n[j] = (j < ppp);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_UNCFG;
      cnt   <= '0;
    end else begin
      if (pass_acc)      cnt <= CNTW'(MP_LAT);
      else if (cnt != 0) cnt <= cnt - 1'b1;
      case (state)
        ST_UNCFG: if (cfg_acc) state <= ST_IDLE;
        default:  state <= (pass_acc || cnt > 1) ? ST_BUSY : ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_u    <= '0;
      mul_en   <= '0;
      lane_cap <= '0;
      for (int t = 0; t < NTAP; t++) begin
        coef_q[t] <= '0;
        grp_q[t]  <= '0;
      end
      for (int j = 0; j < NMUL; j++) begin
        pix_sel[j] <= '0;
        grp_sel[j] <= '0;
      end
    end else if (cfg_acc) begin
      cfg_u    <= cfg_uniq;
      mul_en   <= en_n;
      lane_cap <= cap_n;
      for (int t = 0; t < NTAP; t++) begin
        coef_q[t] <= $signed(cfg_coef[t*CW +: CW]);
        grp_q[t]  <= cfg_grp[t*UW +: UW];
      end
      for (int j = 0; j < NMUL; j++) begin
        pix_sel[j] <= pix_n[j];
        grp_sel[j] <= grp_n[j];
      end
    end
  end

  // R2: a configured block always holds a legal count
  p_u_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_UNCFG) |-> (cfg_u >= 1 && int'(cfg_u) <= NTAP));

  // R3: configuration frozen while passes are in flight
  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY) |=> ($stable(cfg_u) && $stable(lane_cap) && $stable(mul_en)));

  // R3: busy state agrees with the datapath's own stage flags
  p_busy_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY) == pipe_busy);

endmodule

// File: rtl/mp_grpsum.sv
module mp_grpsum #(
  parameter int NMUL = 18,
  parameter int NTAP = 9,
  parameter int DW   = 8,
  parameter int UW   = 4,
  parameter int GW   = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pass_acc,
  input  logic [NMUL*NTAP*DW-1:0]  in_win,
  input  logic [NMUL-1:0]          in_lanes,
  input  logic [NMUL-1:0]          lane_cap,
  input  logic [UW-1:0]            grp_q [NTAP],
  output logic [GW-1:0]            gsum [NMUL][NTAP],
  output logic [NMUL-1:0]          lanes_a,
  output logic                     v_a
);

  logic [GW-1:0]   gs_n [NMUL][NTAP];
  logic [NMUL-1:0] keep;

  assign keep = in_lanes & lane_cap;

  always_comb begin
    for (int p = 0; p < NMUL; p++) begin
      for (int g = 0; g < NTAP; g++) begin
        int acc;
        acc = 0;
        for (int t = 0; t < NTAP; t++)
          if (int'(grp_q[t]) == g)
            acc += int'(in_win[(p*NTAP+t)*DW +: DW]);
        gs_n[p][g] = keep[p] ? GW'(acc) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_a     <= 1'b0;
      lanes_a <= '0;
      for (int p = 0; p < NMUL; p++)
        for (int g = 0; g < NTAP; g++)
          gsum[p][g] <= '0;
    end else begin
      v_a <= pass_acc;
      if (pass_acc) begin
        lanes_a <= keep;
        gsum    <= gs_n;
      end
    end
  end

endmodule

// File: rtl/mp_mulbank.sv
module mp_mulbank #(
  parameter int NMUL = 18,
  parameter int NTAP = 9,
  parameter int CW   = 8,
  parameter int UW   = 4,
  parameter int PXW  = 5,
  parameter int GW   = 12,
  parameter int PW   = 21
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_a,
  input  logic [NMUL-1:0]      lanes_a,
  input  logic [GW-1:0]        gsum [NMUL][NTAP],
  input  logic [PXW-1:0]       pix_sel [NMUL],
  input  logic [UW-1:0]        grp_sel [NMUL],
  input  logic [NMUL-1:0]      mul_en,
  input  logic signed [CW-1:0] coef_q [NTAP],
  output logic signed [PW-1:0] prod [NMUL],
  output logic [NMUL-1:0]      lanes_b,
  output logic                 v_b
);

  for (genvar j = 0; j < NMUL; j++) begin : g_mul
    logic signed [GW:0] opd;
    assign opd = $signed({1'b0, gsum[pix_sel[j]][grp_sel[j]]});
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             prod[j] <= '0;
      else if (v_a) begin
        if (mul_en[j])        prod[j] <= opd * coef_q[grp_sel[j]];
        else                  prod[j] <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_b     <= 1'b0;
      lanes_b <= '0;
    end else begin
      v_b <= v_a;
      if (v_a) lanes_b <= lanes_a;
    end
  end

endmodule

// File: rtl/mp_outsum.sv
module mp_outsum #(
  parameter int NMUL = 18,
  parameter int NTAP = 9,
  parameter int UW   = 4,
  parameter int PW   = 21,
  parameter int OW   = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_b,
  input  logic [NMUL-1:0]      lanes_b,
  input  logic signed [PW-1:0] prod [NMUL],
  input  logic [UW-1:0]        cfg_u,
  output logic signed [OW-1:0] res [NMUL],
  output logic [NMUL-1:0]      out_lanes,
  output logic                 out_valid
);

  logic signed [OW-1:0] sum_n [NMUL];

  always_comb begin
    int u;
    u = int'(cfg_u);
    for (int p = 0; p < NMUL; p++) begin
      sum_n[p] = '0;
      for (int g = 0; g < NTAP; g++) begin
        int idx;
        idx = p * u + g;
        if (g < u && idx < NMUL)
          sum_n[p] = sum_n[p] + OW'(prod[idx]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_lanes <= '0;
      for (int p = 0; p < NMUL; p++) res[p] <= '0;
    end else begin
      out_valid <= v_b;
      out_lanes <= v_b ? lanes_b : '0;
      if (v_b)
        for (int p = 0; p < NMUL; p++)
          res[p] <= lanes_b[p] ? sum_n[p] : '0;
    end
  end

endmodule

// File: rtl/mpool_conv.sv
module mpool_conv
  import mp_pkg::*;
#(
  parameter int NMUL = MP_NMUL,
  parameter int NTAP = MP_NTAP,
  parameter int DW   = 8,
  parameter int CW   = 8
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           cfg_load,
  input  logic [$clog2(NTAP+1)-1:0]                      cfg_uniq,
  input  logic [NTAP*CW-1:0]                             cfg_coef,
  input  logic [NTAP*$clog2(NTAP+1)-1:0]                 cfg_grp,
  input  logic                                           in_valid,
  input  logic [NMUL-1:0]                                in_lanes,
  input  logic [NMUL*NTAP*DW-1:0]                        in_win,
  output logic                                           out_valid,
  output logic [NMUL-1:0]                                out_lanes,
  output logic [NMUL*(DW+CW+1+2*$clog2(NTAP+1))-1:0]     out_pix
);

  localparam int UW  = $clog2(NTAP + 1);
  localparam int PXW = $clog2(NMUL);
  localparam int GW  = DW + UW;
  localparam int PW  = GW + 1 + CW;
  localparam int OW  = PW + UW;

  logic                 pass_acc, pipe_busy, v_a, v_b;
  logic [UW-1:0]        cfg_u;
  logic signed [CW-1:0] coef_q [NTAP];
  logic [UW-1:0]        grp_q [NTAP];
  logic [PXW-1:0]       pix_sel [NMUL];
  logic [UW-1:0]        grp_sel [NMUL];
  logic [NMUL-1:0]      mul_en, lane_cap, lanes_a, lanes_b;
  logic [GW-1:0]        gsum [NMUL][NTAP];
  logic signed [PW-1:0] prod [NMUL];
  logic signed [OW-1:0] res [NMUL];

  assign pipe_busy = v_a || v_b || out_valid;

  mp_ctrl #(.NMUL(NMUL), .NTAP(NTAP), .CW(CW), .UW(UW), .PXW(PXW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_uniq(cfg_uniq),
    .cfg_coef(cfg_coef), .cfg_grp(cfg_grp), .in_valid(in_valid),
    .pipe_busy(pipe_busy), .pass_acc(pass_acc), .cfg_u(cfg_u),
    .coef_q(coef_q), .grp_q(grp_q), .pix_sel(pix_sel), .grp_sel(grp_sel),
    .mul_en(mul_en), .lane_cap(lane_cap)
  );

  mp_grpsum #(.NMUL(NMUL), .NTAP(NTAP), .DW(DW), .UW(UW), .GW(GW)) u_grpsum (
    .clk(clk), .rst_n(rst_n), .pass_acc(pass_acc), .in_win(in_win),
    .in_lanes(in_lanes), .lane_cap(lane_cap), .grp_q(grp_q),
    .gsum(gsum), .lanes_a(lanes_a), .v_a(v_a)
  );

  mp_mulbank #(.NMUL(NMUL), .NTAP(NTAP), .CW(CW), .UW(UW), .PXW(PXW),
               .GW(GW), .PW(PW)) u_mulbank (
    .clk(clk), .rst_n(rst_n), .v_a(v_a), .lanes_a(lanes_a), .gsum(gsum),
    .pix_sel(pix_sel), .grp_sel(grp_sel), .mul_en(mul_en), .coef_q(coef_q),
    .prod(prod), .lanes_b(lanes_b), .v_b(v_b)
  );

  mp_outsum #(.NMUL(NMUL), .NTAP(NTAP), .UW(UW), .PW(PW), .OW(OW)) u_outsum (
    .clk(clk), .rst_n(rst_n), .v_b(v_b), .lanes_b(lanes_b), .prod(prod),
    .cfg_u(cfg_u), .res(res), .out_lanes(out_lanes), .out_valid(out_valid)
  );

  for (genvar p = 0; p < NMUL; p++) begin : g_pack
    assign out_pix[p*OW +: OW] = res[p];
  end

  // R7: fixed latency from pass acceptance to result
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(pass_acc, 3));

  // R6: no result lane beyond the pixels-per-pass count
  p_lane_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_lanes & ~lane_cap) == '0));

endmodule

// File: tb/mpool_conv_tb.sv
module mpool_conv_tb;

  localparam int NM = 18;
  localparam int NT = 9;
  localparam int OW = 25;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_load = 1'b0;
  logic [3:0]       cfg_uniq = '0;
  logic [NT*8-1:0]  cfg_coef = '0;
  logic [NT*4-1:0]  cfg_grp = '0;
  logic             in_valid = 1'b0;
  logic [NM-1:0]    in_lanes = '0;
  logic [NM*NT*8-1:0] in_win = '0;
  logic             out_valid;
  logic [NM-1:0]    out_lanes;
  logic [NM*OW-1:0] out_pix;

  int chk = 0;
  int fails = 0;

  // reference model state
  bit m_cfgd = 0;
  int m_u = 0;
  int m_coef [NT];
  int m_grp [NT];
  bit ev [3];
  logic [NM-1:0] el [3];
  int ep [3][NM];

  int tb_coef [NT];
  int tb_grp [NT];

  mpool_conv u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_uniq(cfg_uniq),
    .cfg_coef(cfg_coef), .cfg_grp(cfg_grp), .in_valid(in_valid),
    .in_lanes(in_lanes), .in_win(in_win), .out_valid(out_valid),
    .out_lanes(out_lanes), .out_pix(out_pix)
  );

  always #5 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", chk, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    fails++;
    summary();
    $finish;
  end

  task automatic put_cfg(input int u);
    cfg_uniq = 4'(u);
    for (int t = 0; t < NT; t++) begin
      cfg_coef[t*8 +: 8] = 8'(tb_coef[t]);
      cfg_grp[t*4 +: 4]  = 4'(tb_grp[t]);
    end
    cfg_load = 1'b1;
  endtask

  task automatic put_pass(input logic [NM-1:0] lanes);
    for (int b = 0; b < NM*NT; b++) in_win[b*8 +: 8] = 8'($urandom_range(255));
    in_lanes = lanes;
    in_valid = 1'b1;
  endtask

  // one clock: model update at the edge, compare after it
  task automatic step(input string tag);
    bit busy, acc_p, acc_c;
    int ppp, u_in;
    @(posedge clk);
    busy  = ev[0] | ev[1] | ev[2];
    u_in  = int'(cfg_uniq);
    acc_p = in_valid && m_cfgd;
    acc_c = cfg_load && !in_valid && !busy && u_in >= 1 && u_in <= 9;
    ev[2] = ev[1]; el[2] = el[1]; ep[2] = ep[1];
    ev[1] = ev[0]; el[1] = el[0]; ep[1] = ep[0];
    ev[0] = acc_p; el[0] = '0;
    ppp = m_cfgd ? NM / m_u : 0;
    for (int p = 0; p < NM; p++) begin
      int s;
      s = 0;
      if (acc_p && p < ppp && in_lanes[p]) begin
        el[0][p] = 1'b1;
        for (int t = 0; t < NT; t++)
          if (m_grp[t] < m_u)
            s += int'(in_win[(p*NT+t)*8 +: 8]) * m_coef[m_grp[t]];
      end
      ep[0][p] = s;
    end
    if (acc_c) begin
      m_cfgd = 1;
      m_u = u_in;
      for (int t = 0; t < NT; t++) begin
        m_coef[t] = int'($signed(cfg_coef[t*8 +: 8]));
        m_grp[t]  = int'(cfg_grp[t*4 +: 4]);
      end
    end
    #1;
    chk++;
    if (out_valid !== ev[2] || out_lanes !== el[2]) begin
      fails++;
      $display("FAIL %s: valid/lanes actual %b/%h expected %b/%h",
               tag, out_valid, out_lanes, ev[2], el[2]);
    end else if (ev[2]) begin
      for (int p = 0; p < NM; p++) begin
        int a;
        a = int'($signed(out_pix[p*OW +: OW]));
        if (a != ep[2][p]) begin
          fails++;
          $display("FAIL %s: lane %0d actual %0d expected %0d", tag, p, a, ep[2][p]);
          break;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    cfg_load = 1'b0;
  endtask

  task automatic flush(input string tag);
    repeat (4) step(tag);
  endtask

  task automatic rand_mask(input int u);
    for (int t = 0; t < NT; t++) begin
      tb_coef[t] = $urandom_range(255);
      tb_grp[t]  = t % u;
    end
    for (int t = 0; t < NT; t++) begin
      int k, x;
      k = $urandom_range(NT-1);
      x = tb_grp[t]; tb_grp[t] = tb_grp[k]; tb_grp[k] = x;
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin ev[i] = 0; el[i] = '0; end
    repeat (5) @(negedge clk);
    // R1: reset state
    chk++;
    if (out_valid !== 1'b0 || out_lanes !== '0) begin
      fails++;
      $display("FAIL R1: reset actual %b/%h expected 0/0", out_valid, out_lanes);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1: passes before any configuration are dropped
    put_pass('1); step("R1");
    put_pass('1); step("R1");
    flush("R1");

    // R2: zero count rejected, block stays unconfigured
    rand_mask(1); put_cfg(0); step("R2");
    put_pass('1); step("R2");
    flush("R2");

    // R5: single coefficient, all taps in group 0, full pool of 18 lanes
    for (int t = 0; t < NT; t++) begin tb_coef[t] = 0; tb_grp[t] = 0; end
    tb_coef[0] = 1;
    put_cfg(1); step("R4");
    put_pass('1); step("R5");
    put_pass(18'h2A5C3); step("R6");
    flush("R7");

    // R8: middle row grouped out of range contributes nothing
    tb_grp = '{0, 0, 0, 7, 7, 7, 1, 1, 1};
    tb_coef = '{-1, 1, 0, 0, 0, 0, 0, 0, 0};
    put_cfg(2); step("R8");
    put_pass('1); step("R8");
    flush("R8");

    // R4 / R7: every count, back-to-back passes with partial lanes
    for (int u = 1; u <= 9; u++) begin
      rand_mask(u); put_cfg(u); step("R4");
      put_pass('1); step("R4");
      put_pass(18'($urandom)); step("R6");
      put_pass('1); step("R7");
      flush("R7");
    end

    // R3: load together with a pass is ignored
    rand_mask(9); put_cfg(9); step("R3");
    rand_mask(1); put_cfg(1); put_pass('1); step("R3");
    put_pass('1); step("R3");
    flush("R3");
    // R3: load one, two and three cycles after a pass is ignored
    for (int d = 1; d <= 3; d++) begin
      put_pass('1); step("R3");
      for (int k = 1; k < d; k++) step("R3");
      rand_mask(3); put_cfg(3); step("R3");
      flush("R3");
      put_pass('1); step("R3");
      flush("R3");
    end
    // R3: load exactly after the busy window is accepted
    put_pass('1); step("R3");
    step("R3"); step("R3"); step("R3");
    rand_mask(4); put_cfg(4); step("R3");
    put_pass('1); step("R3");
    flush("R3");

    // R2: out-of-range counts keep the prior configuration
    rand_mask(1); put_cfg(10); step("R2");
    put_pass('1); step("R2");
    flush("R2");
    rand_mask(2); put_cfg(15); step("R2");
    put_pass('1); step("R2");
    flush("R2");

    summary();
    $finish;
  end

endmodule